// File: doc/BRIEF.md
# Reverse Map Entry Address Locator

This block turns a system physical address into the memory address of the 16-byte reverse-map entry that describes the 4KB page holding it. It runs in one of two layouts. In the flat layout the entries form one run that follows a 16KB bookkeeping header. In the segmented layout the physical space is cut into equal power-of-two segments, and each segment has its own run of entries. An 8-byte descriptor in a 4KB segment table that follows the same header locates each run.

A lookup is one request. The block checks the table configuration and the segment limits first. In the segmented layout it then reads the segment descriptor through a 64-bit read port, unless the descriptor is already held in its one-entry cache. It returns either the entry address or a 2-bit fault code. Writing the configuration drops the cached descriptor.

Top module: `rmp_entry_locator`

## Requirements
- R1: In the flat layout (cfg_ctrl bit 0 = 0), a covered address returns fault 0 and entry address base + 0x4000 + (spa >> 12) * 16, which is always 16-byte aligned.
- R2: In the flat layout, an spa at or above ((end + 1 - base - 0x4000) / 16) * 4096 returns fault 1 (not covered) with address 0.
- R3: If base or end + 1 is not a multiple of 8KB, every lookup returns fault 2 (configuration error) in both layouts, and no memory read is issued.
- R4: In the segmented layout (cfg_ctrl bit 0 = 1, segment size log2 in cfg_ctrl[13:8]), the descriptor index is spa >> log2, and the descriptor is read at base + 0x4000 + index * 8. Reads happen only in this layout.
- R5: A fetched descriptor gives a segment base of bits [51:20] shifted left by 20. The entry address is that base + ((spa - (index << log2)) >> 12) * 16, with fault 0.
- R6: A descriptor whose mapped size (bits [19:0], in GB) is zero, or an offset into the segment at or above mapped size << 30, returns fault 1 with address 0.
- R7: An index of 512 or more, or, while seg_cap_hard is 1, an index at or above seg_cap, returns fault 3 with no memory read. Fault 2 takes precedence over fault 3, and fault 3 over fault 1.
- R8: A lookup whose index matches the last fetched descriptor reuses it without a memory read. A cfg_wr pulse drops the cached descriptor, so the next lookup reads again.
- R9: req_ready is high only while the block is idle. Each accepted request produces exactly one single-cycle res_valid pulse, and res_addr is 0 whenever res_fault is nonzero.
- R10: While mem_rd_valid is high and mem_rd_ready is low, mem_rd_valid stays high and mem_rd_addr stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | PA_W | Address of the first table byte |
| cfg_end | input | PA_W | Address of the last table byte |
| cfg_ctrl | input | 16 | Bit 0 selects the segmented layout; [13:8] give the segment size log2 |
| cfg_wr | input | 1 | Pulse marking a configuration write |
| seg_cap_hard | input | 1 | The segment count cap is enforced |
| seg_cap | input | CAP_W | Usable segment count when the cap is enforced |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_spa | input | PA_W | Physical address to locate |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | PA_W | Descriptor address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor data |
| res_valid | output | 1 | One-cycle result pulse |
| res_addr | output | PA_W | Entry address, 0 on fault |
| res_fault | output | 2 | 0 none, 1 not covered, 2 configuration error, 3 index beyond limit |

## Verification
The bench probes the flat coverage limit on both sides of the boundary: a wrong limit formula would either fault on the last covered page or hand out an address past the table end. It misaligns the base and the end in turn, and uses the top segment index 511, index 512 and the enforced cap with its value on both sides of the index, where an off-by-one would read a descriptor that does not exist. It counts memory reads across repeated segments and across configuration writes, so a stale or missing cache shows up as an extra or missing read. It also stalls the read handshake to catch an address that moves before it is accepted.

// File: rtl/rmp_entry_locator.sv
module rmp_entry_locator #(
  parameter int PA_W    = 52,
  parameter int CAP_W   = 10,
  parameter int MAX_SEG = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [PA_W-1:0]  cfg_end,
  input  logic [15:0]      cfg_ctrl,
  input  logic             cfg_wr,
  input  logic             seg_cap_hard,
  input  logic [CAP_W-1:0] seg_cap,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PA_W-1:0]  req_spa,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             res_valid,
  output logic [PA_W-1:0]  res_addr,
  output logic [1:0]       res_fault
);
  localparam int IDX_W = $clog2(MAX_SEG);
  localparam logic [63:0] HDR = 64'h4000;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_CALC, S_DONE} state_t;
  state_t state;

  logic [PA_W-1:0]  spa_q;
  logic [63:0]      desc_q;
  logic [IDX_W-1:0] c_idx;
  logic             c_vld;

  logic [63:0] base64, end1, span, idx_in, idx_q, off, sbase;
  logic [5:0]  lg;
  logic        seg_mode, cfg_bad, hit_in;

  assign base64   = 64'(cfg_base);
  assign end1     = 64'(cfg_end) + 64'd1;
  assign seg_mode = cfg_ctrl[0];
  assign lg       = cfg_ctrl[13:8];
  assign cfg_bad  = (|base64[12:0]) || (|end1[12:0]);
  assign span     = (end1 > base64 + HDR) ? end1 - base64 - HDR : 64'd0;
  assign idx_in   = 64'(req_spa) >> lg;
  assign idx_q    = 64'(spa_q) >> lg;
  assign off      = 64'(spa_q) - (idx_q << lg);
  assign sbase    = {12'd0, desc_q[51:20], 20'd0};
  assign hit_in   = c_vld && (c_idx == idx_in[IDX_W-1:0]);

  function automatic logic over_lim(input logic [63:0] idx);
    return (idx >= 64'(MAX_SEG)) || (seg_cap_hard && idx >= 64'(seg_cap));
  endfunction

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_FETCH);
  assign res_valid    = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      spa_q       <= '0;
      desc_q      <= '0;
      c_idx       <= '0;
      c_vld       <= 1'b0;
      mem_rd_addr <= '0;
      res_addr    <= '0;
      res_fault   <= 2'd0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          spa_q       <= req_spa;
          mem_rd_addr <= PA_W'(base64 + HDR + (idx_in << 3));
          if (seg_mode && !cfg_bad && !over_lim(idx_in) && !hit_in) state <= S_FETCH;
          else state <= S_CALC;
        end
        S_FETCH: if (mem_rd_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_data;
          c_idx  <= idx_q[IDX_W-1:0];
          c_vld  <= 1'b1;
          state  <= S_CALC;
        end
        S_CALC: begin
          state     <= S_DONE;
          res_addr  <= '0;
          res_fault <= 2'd0;
          if (cfg_bad) res_fault <= 2'd2;
          else if (!seg_mode) begin
            if (64'(spa_q) >= (span << 8)) res_fault <= 2'd1;
            else res_addr <= PA_W'(base64 + HDR + ((64'(spa_q) >> 12) << 4));
          end else if (over_lim(idx_q)) res_fault <= 2'd3;
          else if (desc_q[19:0] == 20'd0 || off >= (64'(desc_q[19:0]) << 30)) res_fault <= 2'd1;
          else res_addr <= PA_W'(sbase + ((off >> 12) << 4));
        end
        default: state <= S_IDLE;
      endcase
      if (cfg_wr) c_vld <= 1'b0;
    end
  end

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'd0 |-> res_addr == '0);
  assert_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 |-> res_addr[3:0] == 4'd0);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  assert_rd_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> cfg_ctrl[0]);
endmodule

// File: tb/sim_rmp_entry_locator.sv
module sim_rmp_entry_locator;
  localparam int CLK_PERIOD = 10;
  localparam logic [51:0] B = 52'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [51:0] cfg_base = '0, cfg_end = '0, req_spa = '0;
  logic [15:0] cfg_ctrl = '0;
  logic cfg_wr = 1'b0, seg_cap_hard = 1'b0, req_valid = 1'b0;
  logic [9:0] seg_cap = '0;
  logic req_ready, mem_rd_valid, mem_rd_ready, mem_rsp_valid, res_valid;
  logic [51:0] mem_rd_addr, res_addr;
  logic [63:0] mem_rsp_data;
  logic [1:0] res_fault;

  int checks = 0, fails = 0, done_cnt = 0, rd_count = 0, cycles = 0;
  logic [51:0] last_addr = '0;
  logic [51:0] exp_addr_q[$];
  logic [1:0]  exp_flt_q[$];
  string       exp_tag_q[$];
  logic [63:0] desc_mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmp_entry_locator u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_end(cfg_end),
    .cfg_ctrl(cfg_ctrl), .cfg_wr(cfg_wr), .seg_cap_hard(seg_cap_hard),
    .seg_cap(seg_cap), .req_valid(req_valid), .req_ready(req_ready),
    .req_spa(req_spa), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_addr(res_addr),
    .res_fault(res_fault));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: stalls every other read by one cycle
  initial begin
    bit stall = 1'b1;
    logic [51:0] a0;
    logic [63:0] ix;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid && !mem_rd_ready) begin
        if (stall) begin
          a0 = mem_rd_addr;
          @(negedge clk);
          chk(mem_rd_valid && mem_rd_addr == a0, "R10 read held under stall", 64'(mem_rd_addr), 64'(a0));
        end
        stall = !stall;
        mem_rd_ready = 1'b1;
        last_addr = mem_rd_addr;
        rd_count++;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        ix = (64'(last_addr) - 64'(cfg_base) - 64'h4000) >> 3;
        mem_rsp_data = (ix < 16) ? desc_mem[ix[3:0]] : 64'd0;
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_addr_q.size() == 0) chk(1'b0, "R9 unexpected result", 64'(res_addr), 64'd0);
      else begin
        logic [51:0] ea;
        logic [1:0] ef;
        string t;
        ea = exp_addr_q.pop_front(); ef = exp_flt_q.pop_front(); t = exp_tag_q.pop_front();
        chk(res_fault == ef, {t, " fault"}, 64'(res_fault), 64'(ef));
        chk(res_addr == ea, {t, " addr"}, 64'(res_addr), 64'(ea));
      end
      done_cnt++;
    end
  end

  task automatic set_cfg(input logic [51:0] b, input logic [51:0] e, input logic [15:0] c);
    @(negedge clk);
    cfg_base = b; cfg_end = e; cfg_ctrl = c; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic lookup(input logic [51:0] spa, input logic [51:0] ea, input logic [1:0] ef,
                        input int fetches, input logic [51:0] faddr, input string tag);
    int c0, target;
    c0 = rd_count;
    target = done_cnt + 1;
    exp_addr_q.push_back(ea); exp_flt_q.push_back(ef); exp_tag_q.push_back(tag);
    @(negedge clk);
    chk(req_ready, "R9 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_spa = spa;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", 64'(req_ready), 64'd0);
    while (done_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rd_count - c0 == fetches, {tag, " R8 read count"}, 64'(rd_count - c0), 64'(fetches));
    if (fetches != 0) chk(last_addr == faddr, {tag, " R4 descriptor address"}, 64'(last_addr), 64'(faddr));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) desc_mem[i] = 64'd0;
    desc_mem[0] = (64'h200 << 20) | 64'd1;
    desc_mem[2] = (64'h300 << 20) | 64'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !res_valid && !mem_rd_valid, "R9 reset state",
        {61'd0, req_ready, res_valid, mem_rd_valid}, 64'h4);

    // flat layout, 512 entries: covers 0 .. 0x1FFFFF
    set_cfg(B, B + 52'h6000 - 1, 16'h0000);
    lookup(52'h0, B + 52'h4000, 2'd0, 0, '0, "R1 first page");
    lookup(52'h12345, B + 52'h4120, 2'd0, 0, '0, "R1 mid page");
    lookup(52'h1FFFFF, B + 52'h5FF0, 2'd0, 0, '0, "R2 last covered page");
    lookup(52'h200000, '0, 2'd1, 0, '0, "R2 first uncovered");
    lookup(52'h7FFF_FFFF, '0, 2'd1, 0, '0, "R2 far above");

    // misaligned configurations
    set_cfg(B + 52'h1000, B + 52'h6000 - 1, 16'h0000);
    lookup(52'h0, '0, 2'd2, 0, '0, "R3 base misaligned");
    set_cfg(B, B + 52'h7000 - 1, 16'h0000);
    lookup(52'h0, '0, 2'd2, 0, '0, "R3 end misaligned");
    set_cfg(B + 52'h1000, B + 52'h6000 - 1, 16'h1E01);
    lookup(52'h5000, '0, 2'd2, 0, '0, "R3 segmented misaligned");

    // segmented layout, 1GB segments
    set_cfg(B, B + 52'h6000 - 1, 16'h1E01);
    lookup(52'h5000, 52'h2000_0050, 2'd0, 1, B + 52'h4000, "R5 segment 0");
    lookup(52'h7000, 52'h2000_0070, 2'd0, 0, '0, "R8 cached segment");
    lookup(52'h8000_3000, 52'h3000_0030, 2'd0, 1, B + 52'h4010, "R5 segment 2");
    lookup(52'h4000_0000, '0, 2'd1, 1, B + 52'h4008, "R6 zero mapped size");
    lookup(52'h80_0000_0000, '0, 2'd3, 0, '0, "R7 index 512");
    lookup(52'h7F_C000_0000, '0, 2'd1, 1, B + 52'h4FF8, "R4 index 511");
    seg_cap_hard = 1'b1; seg_cap = 10'd2;
    lookup(52'h8000_3000, '0, 2'd3, 0, '0, "R7 index at cap");
    seg_cap = 10'd3;
    lookup(52'h8000_3000, 52'h3000_0030, 2'd0, 1, B + 52'h4010, "R7 index below cap");
    seg_cap_hard = 1'b0; seg_cap = 10'd0;
    lookup(52'h8000_4000, 52'h3000_0040, 2'd0, 0, '0, "R8 cached with cap off");

    // 2GB segments; configuration write drops the cache
    set_cfg(B, B + 52'h6000 - 1, 16'h1F01);
    lookup(52'h4000_0000, '0, 2'd1, 1, B + 52'h4000, "R6 beyond mapped size");
    lookup(52'h3FFF_F000, 52'h203F_FFF0, 2'd0, 0, '0, "R5 last mapped page");
    lookup(52'h8000_0000, '0, 2'd1, 1, B + 52'h4008, "R6 segment 1 empty");
    set_cfg(B, B + 52'h6000 - 1, 16'h1F01);
    lookup(52'h8000_0000, '0, 2'd1, 1, B + 52'h4008, "R8 refetch after write");

    chk(exp_addr_q.size() == 0, "R9 results outstanding", 64'(exp_addr_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule